// File: doc/BRIEF.md
# Ring Router Handshake Controller

This block sequences the control side of one node's router on a one-way ring. There are three sources of work. The local processor can send a word out onto the ring. The processor can collect a word that arrives from upstream. A word from upstream can also be forwarded unchanged to the downstream neighbour. The controller is a Moore machine with one idle state and three fixed four-state sequences. It decodes its strobes from the registered state only, so they are free of glitches. The strobes drive an input latch, a write latch and the tri-state drivers that sit around them. The latches and drivers themselves are outside this block.

All three ports use four-phase request/acknowledge handshakes: the processor port, the upstream link and the downstream link. The machine leaves a sequence only after the request or acknowledge it waits on has returned low. It then goes back to idle. When idle sees more than one request, it serves them in a fixed order: the upstream word first, then the processor read, then the processor write. The state register can be binary or one-hot, and the strobes can come from the current-state decoder or from a register. Every combination gives the same behaviour cycle for cycle.

Top module: `ring_hs_ctrl`

## Requirements
- R1: While `rst` is sampled high at a rising edge, the machine enters idle. In idle, all nine strobe outputs are 0 from the following cycle on.
- R2: Idle picks its next sequence by fixed priority: `lnk_in_req` first, then `rd_req`, then `wr_req`. The chosen sequence starts at the next rising edge.
- R3: Write sequence. `wr_lat_clk` is high for exactly one cycle. Then `wr_drv_en` and `lnk_out_req` are high until `lnk_out_ack` is sampled high. Then only `wr_drv_en` is high until `lnk_out_ack` is sampled low. Then only `wr_ack` is high until `wr_req` is sampled low, after which the machine is idle.
- R4: Pass sequence. `in_lat_clk` is high for one cycle. Then `lnk_in_ack` is high alone until `lnk_in_req` is sampled low. Then `in_drv_en` and `lnk_out_req` are high until `lnk_out_ack` is sampled high. Then only `in_drv_en` is high until `lnk_out_ack` is sampled low, after which the machine is idle.
- R5: Read sequence. First all outputs stay 0 while the machine waits for `lnk_in_req`. Then `in_lat_clk` is high for one cycle. Then `lnk_in_ack`, `in_drv_en` and `rd_drv_en` are high until `lnk_in_req` is sampled low. Then `in_drv_en`, `rd_drv_en` and `rd_ack` are high until `rd_req` is sampled low, after which the machine is idle.
- R6: `wr_drv_en` and `in_drv_en` are never high together. `rd_drv_en` is high only while `in_drv_en` is high.
- R7: Four-phase discipline. An asserted `lnk_out_req`, `lnk_in_ack`, `wr_ack` or `rd_ack` stays high until the matching partner signal is sampled in its completing level. `lnk_out_req` drops in the cycle after `lnk_out_ack` is sampled high.
- R8: Suppose the latches are clocked by the two latch strobes and the drivers are enabled by the driver strobes. Then every word offered on the upstream link reaches exactly one destination, the downstream link or the processor, and reaches it exactly once. Every processor write reaches the downstream link exactly once.
- R9: A reset asserted in the middle of a sequence returns every output to 0 after the next rising edge. Operation then resumes from idle.
- R10: Every combination of `STATE_ENC` (0 = binary, 1 = one-hot) and `OUT_REG` (0 = decoded, 1 = registered) produces the same output waveform for the same inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_req | input | 1 | Processor asks to send a word onto the ring |
| rd_req | input | 1 | Processor asks to collect a word from the ring |
| lnk_in_req | input | 1 | Upstream neighbour offers a word |
| lnk_out_ack | input | 1 | Downstream neighbour has taken the word |
| rd_drv_en | output | 1 | Enables the driver from the input latch to the processor bus |
| wr_drv_en | output | 1 | Enables the write latch onto the downstream link |
| wr_lat_clk | output | 1 | Clocks the processor word into the write latch |
| in_drv_en | output | 1 | Enables the input latch onto its output bus |
| in_lat_clk | output | 1 | Clocks the upstream word into the input latch |
| wr_ack | output | 1 | Acknowledge to the processor for a write |
| rd_ack | output | 1 | Acknowledge to the processor for a read |
| lnk_out_req | output | 1 | Request to the downstream neighbour |
| lnk_in_ack | output | 1 | Acknowledge to the upstream neighbour |

## Verification
The hardest case to reach from the ports is a read that finds the machine already waiting in its quiet read state. That state cannot be told apart from idle at the outputs, and it only completes when an upstream word arrives later. The random neighbours keep offering upstream words while a processor read is outstanding, so every read finishes. Directed cases raise all three requests in the same cycle and step through the priority chain one sequence at a time. A second instance with one-hot state and registered outputs runs next to the first and is compared with it on every cycle.

// File: rtl/ring_hs_pkg.sv
package ring_hs_pkg;

   localparam int NUM_STATES = 13;
   localparam int STATE_W    = $clog2(NUM_STATES);
   localparam int NUM_OUTS   = 9;

   typedef enum logic [STATE_W-1:0] {
      ST_IDLE    = 4'd0,
      ST_W_LAT   = 4'd1,
      ST_W_SEND  = 4'd2,
      ST_W_DRAIN = 4'd3,
      ST_W_ACK   = 4'd4,
      ST_R_WAIT  = 4'd5,
      ST_R_LAT   = 4'd6,
      ST_R_HAND  = 4'd7,
      ST_R_ACK   = 4'd8,
      ST_P_LAT   = 4'd9,
      ST_P_ACK   = 4'd10,
      ST_P_SEND  = 4'd11,
      ST_P_DRAIN = 4'd12
   } hs_state_e;

   typedef struct packed {
      logic wr_req;
      logic rd_req;
      logic in_req;
      logic out_ack;
   } hs_in_t;

   typedef struct packed {
      logic rd_drv_en;
      logic wr_drv_en;
      logic wr_lat_clk;
      logic in_drv_en;
      logic in_lat_clk;
      logic wr_ack;
      logic rd_ack;
      logic lnk_out_req;
      logic lnk_in_ack;
   } hs_out_t;

endpackage

// File: rtl/ring_hs_next.sv
module ring_hs_next
   import ring_hs_pkg::*;
(
   input  hs_state_e cur,
   input  hs_in_t    req,
   output hs_state_e nxt
);

   always_comb begin
      nxt = cur;
      case (cur)
         ST_IDLE: begin
            if (req.in_req)      nxt = ST_P_LAT;
            else if (req.rd_req) nxt = ST_R_WAIT;
            else if (req.wr_req) nxt = ST_W_LAT;
         end
         ST_W_LAT:   nxt = ST_W_SEND;
         ST_W_SEND:  if (req.out_ack)  nxt = ST_W_DRAIN;
         ST_W_DRAIN: if (!req.out_ack) nxt = ST_W_ACK;
         ST_W_ACK:   if (!req.wr_req)  nxt = ST_IDLE;
         ST_R_WAIT:  if (req.in_req)   nxt = ST_R_LAT;
         ST_R_LAT:   nxt = ST_R_HAND;
         ST_R_HAND:  if (!req.in_req)  nxt = ST_R_ACK;
         ST_R_ACK:   if (!req.rd_req)  nxt = ST_IDLE;
         ST_P_LAT:   nxt = ST_P_ACK;
         ST_P_ACK:   if (!req.in_req)  nxt = ST_P_SEND;
         ST_P_SEND:  if (req.out_ack)  nxt = ST_P_DRAIN;
         ST_P_DRAIN: if (!req.out_ack) nxt = ST_IDLE;
         default:    nxt = ST_IDLE;
      endcase
   end

endmodule

// File: rtl/ring_hs_state_reg.sv
module ring_hs_state_reg
   import ring_hs_pkg::*;
#(
   parameter int STATE_ENC = 0
)(
   input  logic      clk,
   input  logic      rst,
   input  hs_state_e nxt,
   output hs_state_e cur
);

   generate
      if (STATE_ENC == 0) begin : g_bin
         hs_state_e st_q;
         always_ff @(posedge clk) begin
            if (rst) st_q <= ST_IDLE;
            else     st_q <= nxt;
         end
         assign cur = st_q;
      end else begin : g_onehot
         logic [NUM_STATES-1:0] oh_q;
         logic [NUM_STATES-1:0] oh_d;
         always_comb begin
            for (int i = 0; i < NUM_STATES; i++)
               oh_d[i] = (nxt == hs_state_e'(STATE_W'(i)));
         end
         always_ff @(posedge clk) begin
            if (rst) oh_q <= NUM_STATES'(1);
            else     oh_q <= oh_d;
         end
         always_comb begin
            cur = ST_IDLE;
            for (int i = 0; i < NUM_STATES; i++)
               if (oh_q[i]) cur = hs_state_e'(STATE_W'(i));
         end
      end
   endgenerate

endmodule

// File: rtl/ring_hs_out_dec.sv
module ring_hs_out_dec
   import ring_hs_pkg::*;
(
   input  hs_state_e st,
   output hs_out_t   o
);

   always_comb begin
      o = '0;
      case (st)
         ST_W_LAT:   o.wr_lat_clk = 1'b1;
         ST_W_SEND:  begin o.wr_drv_en = 1'b1; o.lnk_out_req = 1'b1; end
         ST_W_DRAIN: o.wr_drv_en = 1'b1;
         ST_W_ACK:   o.wr_ack = 1'b1;
         ST_R_LAT:   o.in_lat_clk = 1'b1;
         ST_R_HAND:  begin o.lnk_in_ack = 1'b1; o.in_drv_en = 1'b1; o.rd_drv_en = 1'b1; end
         ST_R_ACK:   begin o.rd_ack = 1'b1; o.in_drv_en = 1'b1; o.rd_drv_en = 1'b1; end
         ST_P_LAT:   o.in_lat_clk = 1'b1;
         ST_P_ACK:   o.lnk_in_ack = 1'b1;
         ST_P_SEND:  begin o.in_drv_en = 1'b1; o.lnk_out_req = 1'b1; end
         ST_P_DRAIN: o.in_drv_en = 1'b1;
         default:    o = '0;
      endcase
   end

endmodule

// File: rtl/ring_hs_ctrl.sv
module ring_hs_ctrl
   import ring_hs_pkg::*;
#(
   parameter int STATE_ENC = 0,
   parameter int OUT_REG   = 0
)(
   input  logic clk,
   input  logic rst,
   input  logic wr_req,
   input  logic rd_req,
   input  logic lnk_in_req,
   input  logic lnk_out_ack,
   output logic rd_drv_en,
   output logic wr_drv_en,
   output logic wr_lat_clk,
   output logic in_drv_en,
   output logic in_lat_clk,
   output logic wr_ack,
   output logic rd_ack,
   output logic lnk_out_req,
   output logic lnk_in_ack
);

   generate
      if (!(STATE_ENC == 0 || STATE_ENC == 1)) begin : g_bad_enc
         $error("ring_hs_ctrl: STATE_ENC must be 0 or 1");
      end
      if (!(OUT_REG == 0 || OUT_REG == 1)) begin : g_bad_oreg
         $error("ring_hs_ctrl: OUT_REG must be 0 or 1");
      end
   endgenerate

   hs_in_t    req_bus;
   hs_state_e cur_st;
   hs_state_e nxt_st;
   hs_out_t   strobes;

   assign req_bus.wr_req  = wr_req;
   assign req_bus.rd_req  = rd_req;
   assign req_bus.in_req  = lnk_in_req;
   assign req_bus.out_ack = lnk_out_ack;

   ring_hs_next u_next (
      .cur (cur_st),
      .req (req_bus),
      .nxt (nxt_st)
   );

   ring_hs_state_reg #(.STATE_ENC(STATE_ENC)) u_state (
      .clk (clk),
      .rst (rst),
      .nxt (nxt_st),
      .cur (cur_st)
   );

   generate
      if (OUT_REG == 0) begin : g_dec_cur
         ring_hs_out_dec u_dec (
            .st (cur_st),
            .o  (strobes)
         );
      end else begin : g_dec_reg
         hs_out_t dec_nxt;
         hs_out_t out_q;
         ring_hs_out_dec u_dec (
            .st (nxt_st),
            .o  (dec_nxt)
         );
         always_ff @(posedge clk) begin
            if (rst) out_q <= '0;
            else     out_q <= dec_nxt;
         end
         assign strobes = out_q;
      end
   endgenerate

   assign rd_drv_en   = strobes.rd_drv_en;
   assign wr_drv_en   = strobes.wr_drv_en;
   assign wr_lat_clk  = strobes.wr_lat_clk;
   assign in_drv_en   = strobes.in_drv_en;
   assign in_lat_clk  = strobes.in_lat_clk;
   assign wr_ack      = strobes.wr_ack;
   assign rd_ack      = strobes.rd_ack;
   assign lnk_out_req = strobes.lnk_out_req;
   assign lnk_in_ack  = strobes.lnk_in_ack;

endmodule

// File: rtl/ring_hs_ctrl_chk.sv
module ring_hs_ctrl_chk (
   input logic clk,
   input logic rst,
   input logic wr_req,
   input logic rd_req,
   input logic lnk_in_req,
   input logic lnk_out_ack,
   input logic rd_drv_en,
   input logic wr_drv_en,
   input logic wr_lat_clk,
   input logic in_drv_en,
   input logic in_lat_clk,
   input logic wr_ack,
   input logic rd_ack,
   input logic lnk_out_req,
   input logic lnk_in_ack
);

   logic [8:0] all_outs;
   assign all_outs = {rd_drv_en, wr_drv_en, wr_lat_clk, in_drv_en, in_lat_clk,
                      wr_ack, rd_ack, lnk_out_req, lnk_in_ack};

   AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> all_outs == 9'd0); // R1

   AST_WLAT_PULSE: assert property (@(posedge clk) disable iff (rst)
      wr_lat_clk |=> !wr_lat_clk); // R3

   AST_ILAT_PULSE: assert property (@(posedge clk) disable iff (rst)
      in_lat_clk |=> !in_lat_clk); // R4

   AST_DRV_EXCL: assert property (@(posedge clk) disable iff (rst)
      !(wr_drv_en && in_drv_en)); // R6

   AST_RD_STEER: assert property (@(posedge clk) disable iff (rst)
      rd_drv_en |-> in_drv_en); // R5

   AST_OREQ_HOLD: assert property (@(posedge clk) disable iff (rst)
      (lnk_out_req && !lnk_out_ack) |=> lnk_out_req); // R7

   AST_OREQ_DROP: assert property (@(posedge clk) disable iff (rst)
      (lnk_out_req && lnk_out_ack) |=> !lnk_out_req); // R7

   AST_IACK_HOLD: assert property (@(posedge clk) disable iff (rst)
      (lnk_in_ack && lnk_in_req) |=> lnk_in_ack); // R7

   AST_WACK_HOLD: assert property (@(posedge clk) disable iff (rst)
      (wr_ack && wr_req) |=> wr_ack); // R3

   AST_RACK_HOLD: assert property (@(posedge clk) disable iff (rst)
      (rd_ack && rd_req) |=> rd_ack); // R5

endmodule

bind ring_hs_ctrl ring_hs_ctrl_chk chk_i (.*);

// File: tb/ring_hs_ctrl_tb_top.sv
module ring_hs_ctrl_tb_top;

   localparam int N_UP   = 60;
   localparam int N_WR   = 60;
   localparam int N_RD   = 30;
   localparam int LIMIT  = 150000;

   localparam logic [8:0] O_RDDRV = 9'h100;
   localparam logic [8:0] O_WRDRV = 9'h080;
   localparam logic [8:0] O_WRLAT = 9'h040;
   localparam logic [8:0] O_INDRV = 9'h020;
   localparam logic [8:0] O_INLAT = 9'h010;
   localparam logic [8:0] O_WACK  = 9'h008;
   localparam logic [8:0] O_RACK  = 9'h004;
   localparam logic [8:0] O_OREQ  = 9'h002;
   localparam logic [8:0] O_IACK  = 9'h001;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst = 1'b1;
   logic auto_en = 1'b0;
   logic mon_en  = 1'b0;
   int   n_chk = 0;
   int   n_err = 0;

   logic d_wr = 0, d_rd = 0, d_ireq = 0, d_oack = 0;
   logic a_wr = 0, a_rd = 0, a_ireq = 0, a_oack = 0;
   logic wr_req, rd_req, lnk_in_req, lnk_out_ack;
   assign wr_req      = auto_en ? a_wr   : d_wr;
   assign rd_req      = auto_en ? a_rd   : d_rd;
   assign lnk_in_req  = auto_en ? a_ireq : d_ireq;
   assign lnk_out_ack = auto_en ? a_oack : d_oack;

   logic rd_drv_en, wr_drv_en, wr_lat_clk, in_drv_en, in_lat_clk;
   logic wr_ack, rd_ack, lnk_out_req, lnk_in_ack;
   logic [8:0] outs, alt_outs;

   ring_hs_ctrl dut_i (
      .clk(clk), .rst(rst), .wr_req(wr_req), .rd_req(rd_req),
      .lnk_in_req(lnk_in_req), .lnk_out_ack(lnk_out_ack),
      .rd_drv_en(rd_drv_en), .wr_drv_en(wr_drv_en), .wr_lat_clk(wr_lat_clk),
      .in_drv_en(in_drv_en), .in_lat_clk(in_lat_clk), .wr_ack(wr_ack),
      .rd_ack(rd_ack), .lnk_out_req(lnk_out_req), .lnk_in_ack(lnk_in_ack));

   ring_hs_ctrl #(.STATE_ENC(1), .OUT_REG(1)) dut_alt (
      .clk(clk), .rst(rst), .wr_req(wr_req), .rd_req(rd_req),
      .lnk_in_req(lnk_in_req), .lnk_out_ack(lnk_out_ack),
      .rd_drv_en(alt_outs[8]), .wr_drv_en(alt_outs[7]), .wr_lat_clk(alt_outs[6]),
      .in_drv_en(alt_outs[5]), .in_lat_clk(alt_outs[4]), .wr_ack(alt_outs[3]),
      .rd_ack(alt_outs[2]), .lnk_out_req(alt_outs[1]), .lnk_in_ack(alt_outs[0]));

   assign outs = {rd_drv_en, wr_drv_en, wr_lat_clk, in_drv_en, in_lat_clk,
                  wr_ack, rd_ack, lnk_out_req, lnk_in_ack};

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
      end
   endtask

   // advance one clock and compare the strobes away from the edge
   task automatic step(input logic [8:0] exp, input string req);
      @(posedge clk);
      @(negedge clk);
      chk(outs === exp, req, 32'(outs), 32'(exp));
   endtask

   function automatic bit is_up(input logic [15:0] w);
      return w[15:12] == 4'h1;
   endfunction
   function automatic bit is_wr(input logic [15:0] w);
      return w[15:12] == 4'h5;
   endfunction

   // bench-side datapath model and delivery scoreboard
   logic [15:0] m_in_latch = '0, m_wr_latch = '0;
   logic [15:0] a_in_data = '0, a_wr_data = '0;
   int up_cnt[256];
   int wr_cnt[256];
   int up_sent = 0, wr_sent = 0, rd_issued = 0, rd_done = 0, bad_word = 0;
   bit rd_got = 0;

   task automatic deliver(input logic [15:0] w);
      if (is_up(w))      up_cnt[w[7:0]]++;
      else if (is_wr(w)) wr_cnt[w[7:0]]++;
      else               bad_word++;
   endtask

   // per-cycle monitor: R6 exclusion and R10 variant equivalence
   always @(negedge clk) begin
      if (mon_en) begin
         chk(!(wr_drv_en && in_drv_en) && (!rd_drv_en || in_drv_en), "R6",
             32'(outs), 32'(outs & ~O_RDDRV));
         chk(alt_outs === outs, "R10", 32'(alt_outs), 32'(outs));
      end
   end

   // reactive four-phase agents for processor and both neighbours
   always @(negedge clk) begin
      if (in_lat_clk) m_in_latch = auto_en ? a_in_data : 16'h0;
      if (wr_lat_clk) m_wr_latch = a_wr_data;
      if (auto_en) begin
         // upstream neighbour
         if (!a_ireq && !lnk_in_ack) begin
            if ((up_sent < N_UP || a_rd) && ($urandom % 4 == 0)) begin
               a_in_data = 16'h1000 | 16'(up_sent);
               up_sent++;
               a_ireq = 1'b1;
            end
         end else if (a_ireq && lnk_in_ack && ($urandom % 2 == 0)) begin
            a_ireq = 1'b0;
         end
         // processor write
         if (!a_wr && !wr_ack) begin
            if (wr_sent < N_WR && ($urandom % 6 == 0)) begin
               a_wr_data = 16'h5000 | 16'(wr_sent);
               wr_sent++;
               a_wr = 1'b1;
            end
         end else if (a_wr && wr_ack && ($urandom % 2 == 0)) begin
            a_wr = 1'b0;
         end
         // processor read
         if (!a_rd && !rd_ack) begin
            if (rd_issued < N_RD && ($urandom % 6 == 0)) begin
               rd_issued++;
               a_rd = 1'b1;
            end
         end else if (a_rd && rd_ack) begin
            if (!rd_got) begin
               rd_got = 1'b1;
               rd_done++;
               if (!(rd_drv_en && in_drv_en) || !is_up(m_in_latch)) bad_word++;
               deliver(m_in_latch);
            end
            if ($urandom % 2 == 0) begin
               a_rd = 1'b0;
               rd_got = 1'b0;
            end
         end
         // downstream neighbour
         if (lnk_out_req && !a_oack) begin
            if ($urandom % 3 == 0) begin
               if (wr_drv_en)      deliver(m_wr_latch);
               else if (in_drv_en) deliver(m_in_latch);
               else                bad_word++;
               a_oack = 1'b1;
            end
         end else if (a_oack && !lnk_out_req && ($urandom % 2 == 0)) begin
            a_oack = 1'b0;
         end
      end
   end

   // watchdog: a hung run counts as a failure and still prints the summary
   initial begin
      repeat (LIMIT) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", LIMIT, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      void'($urandom(32'h1d5e));
      foreach (up_cnt[i]) up_cnt[i] = 0;
      foreach (wr_cnt[i]) wr_cnt[i] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(outs === 9'd0, "R1", 32'(outs), 0);
      chk(alt_outs === 9'd0, "R1", 32'(alt_outs), 0);
      rst = 1'b0;
      mon_en = 1'b1;
      step(9'd0, "R1");

      // R3 write sequence, including held request while no acknowledge
      d_wr = 1;
      step(O_WRLAT, "R3");
      step(O_WRDRV | O_OREQ, "R3");
      step(O_WRDRV | O_OREQ, "R7");
      d_oack = 1;
      step(O_WRDRV, "R3");
      step(O_WRDRV, "R7");
      d_oack = 0;
      step(O_WACK, "R3");
      step(O_WACK, "R7");
      d_wr = 0;
      step(9'd0, "R3");

      // R4 pass sequence
      d_ireq = 1;
      step(O_INLAT, "R4");
      step(O_IACK, "R4");
      step(O_IACK, "R7");
      d_ireq = 0;
      step(O_INDRV | O_OREQ, "R4");
      step(O_INDRV | O_OREQ, "R7");
      d_oack = 1;
      step(O_INDRV, "R4");
      d_oack = 0;
      step(9'd0, "R4");

      // R5 read sequence with quiet wait
      d_rd = 1;
      step(9'd0, "R5");
      step(9'd0, "R5");
      d_ireq = 1;
      step(O_INLAT, "R5");
      step(O_IACK | O_INDRV | O_RDDRV, "R5");
      d_ireq = 0;
      step(O_INDRV | O_RDDRV | O_RACK, "R5");
      step(O_INDRV | O_RDDRV | O_RACK, "R7");
      d_rd = 0;
      step(9'd0, "R5");

      // R2 all three requests together: pass, then read, then write
      d_wr = 1; d_rd = 1; d_ireq = 1;
      step(O_INLAT, "R2");
      step(O_IACK, "R2");
      d_ireq = 0;
      step(O_INDRV | O_OREQ, "R2");
      d_oack = 1;
      step(O_INDRV, "R2");
      d_oack = 0;
      step(9'd0, "R2");
      step(9'd0, "R2");
      d_ireq = 1;
      step(O_INLAT, "R2");
      step(O_IACK | O_INDRV | O_RDDRV, "R2");
      d_ireq = 0;
      step(O_INDRV | O_RDDRV | O_RACK, "R2");
      d_rd = 0;
      step(9'd0, "R2");
      step(O_WRLAT, "R2");
      step(O_WRDRV | O_OREQ, "R2");
      d_oack = 1;
      step(O_WRDRV, "R2");
      d_oack = 0;
      step(O_WACK, "R2");
      d_wr = 0;
      step(9'd0, "R2");

      // R9 reset in the middle of a write
      d_wr = 1;
      step(O_WRLAT, "R9");
      step(O_WRDRV | O_OREQ, "R9");
      rst = 1; d_wr = 0;
      step(9'd0, "R9");
      rst = 0;
      step(9'd0, "R9");
      step(9'd0, "R9");

      // R8 random traffic from all agents at once
      auto_en = 1'b1;
      while (!(wr_sent == N_WR && up_sent >= N_UP && rd_done == N_RD &&
               !a_wr && !a_rd && !a_ireq && !a_oack && outs == 9'd0))
         @(negedge clk);
      repeat (4) @(negedge clk);
      for (int i = 0; i < up_sent; i++)
         chk(up_cnt[i] == 1, "R8", 32'(up_cnt[i]), 1);
      for (int i = 0; i < N_WR; i++)
         chk(wr_cnt[i] == 1, "R8", 32'(wr_cnt[i]), 1);
      chk(bad_word == 0, "R8", 32'(bad_word), 0);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule